// File: doc/BRIEF.md
# Cycle-Stealing Counter Increment Unit

This block gathers count requests from incremental position encoders and from serial input lines, and services each one by borrowing memory cycles from the instruction sequencer. Each request line is tied to one fixed word in memory and to one fixed operation. The operations are add one, add minus one, shift left with a one entering bit 0, and shift left with a zero entering bit 0. The two shift operations build up words from serial bits. Arithmetic is 15-bit ones' complement with end-around carry.

Request pulses set sticky pending flags. The sequencer raises `boundary_i` in cycles that fall between its own memory cycles. If any flag is set in such a cycle, the unit pulses `grant_o` and takes the next three clock cycles. It reads the word, forms the new value, and writes the word back, and it holds `stall_o` high for all three cycles. The memory port is single-ported with a one-cycle read latency.

Top module: `cycle_steal_counter`

## Requirements
- R1: A steal begins only in a cycle where `boundary_i` is high, no steal is in progress, and a request is pending. `grant_o` is high in that cycle. `stall_o` is then high for exactly the three following cycles.
- R2: In the first stolen cycle `mem_rd_o` is high. Read data is taken from `mem_rdata_i` in the second stolen cycle. In the third stolen cycle `mem_wr_o` is high, with the same address as the read.
- R3: Line i always operates on address `BASE + i`. No other address is ever driven during a steal.
- R4: The operation of line i is selected by `OP_MAP[2i+1:2i]`: 0 adds one, 1 adds minus one, 2 shifts left and inserts a one, 3 shifts left and inserts a zero. The default map gives lines 0, 1, 2 and 3 the codes 0, 1, 2 and 3.
- R5: The add operations use ones' complement with end-around carry. Examples: 0x7FFE+1 gives 0x7FFF (negative zero); 0x7FFF+1 gives 0x0001; 0x0000−1 gives 0x7FFE; 0x0001−1 gives 0x7FFF.
- R6: The shift operations drop bit 14 of the old word.
- R7: A request pulse sets a sticky flag that survives until that line is granted. A pulse that arrives while a steal is in progress is serviced later. Several pulses on one line before it is granted cause only one service.
- R8: When several lines are pending, the lowest-numbered line is granted first. Each steal services one line.
- R9: After reset, no requests are pending and `stall_o`, `grant_o`, `mem_rd_o` and `mem_wr_o` are low.
- R10: `mem_rd_o` and `mem_wr_o` are never high outside stolen cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NCH | Count request pulses, one per line |
| boundary_i | input | 1 | Sequencer is between memory cycles |
| grant_o | output | 1 | Steal accepted in this cycle |
| stall_o | output | 1 | Sequencer must hold; memory belongs to this unit |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | W | Write data |
| mem_rdata_i | input | W | Read data, valid one cycle after the read strobe |

## Verification
`grant_o` is combinational, so it is sampled a short delay after the bench raises `boundary_i`, inside the same cycle. `stall_o` first shows up one edge later and is counted at each falling edge until it drops. The result is written to memory on the edge that ends the third stolen cycle, so the bench reads its own memory model only after `stall_o` has fallen. A pending request is set on the edge after its pulse, so the bench always leaves one edge between a pulse and the boundary cycle that should grant it.

// File: rtl/cycle_steal_counter.sv
module cycle_steal_counter #(
  parameter int W = 15,
  parameter int AW = 6,
  parameter int NCH = 4,
  parameter logic [AW-1:0] BASE = 6'h20,
  parameter logic [2*NCH-1:0] OP_MAP = 8'hE4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic           boundary_i,
  output logic           grant_o,
  output logic           stall_o,
  output logic           mem_rd_o,
  output logic           mem_wr_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [W-1:0]   mem_wdata_o,
  input  logic [W-1:0]   mem_rdata_i
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_MOD, S_WR} st_t;

  st_t            st;
  logic [NCH-1:0] pend, clr;
  logic [CW-1:0]  pick, ch;
  logic           any;
  logic [1:0]     op;
  logic [W:0]     sum;
  logic [W-1:0]   addv, nxt, wreg;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) pick = CW'(i);
  end

  assign any     = |pend;
  assign grant_o = boundary_i & any & (st == S_IDLE);
  assign clr     = grant_o ? (NCH'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | req_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ch   <= '0;
      wreg <= '0;
    end else begin
      case (st)
        S_IDLE: if (grant_o) begin st <= S_RD; ch <= pick; end
        S_RD:   st <= S_MOD;
        S_MOD:  begin st <= S_WR; wreg <= nxt; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign op   = OP_MAP[2*int'(ch) +: 2];
  assign sum  = {1'b0, mem_rdata_i} + {1'b0, (op == 2'd0) ? W'(1) : ~W'(1)};
  assign addv = sum[W-1:0] + W'(sum[W]);

  always_comb begin
    case (op)
      2'd0, 2'd1: nxt = addv;
      2'd2:       nxt = {mem_rdata_i[W-2:0], 1'b1};
      default:    nxt = {mem_rdata_i[W-2:0], 1'b0};
    endcase
  end

  assign stall_o     = (st != S_IDLE);
  assign mem_rd_o    = (st == S_RD);
  assign mem_wr_o    = (st == S_WR);
  assign mem_addr_o  = BASE + AW'(ch);
  assign mem_wdata_o = wreg;

  AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> boundary_i && !stall_o); // R1
  AST_THREE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> stall_o ##1 stall_o ##1 stall_o ##1 !stall_o); // R1
  AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_o) |-> mem_rd_o); // R2
  AST_WRITE_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> $past(mem_rd_o, 2) && mem_addr_o == $past(mem_addr_o, 2)); // R2
  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> (int'(mem_addr_o) >= int'(BASE)) && (int'(mem_addr_o) < int'(BASE) + NCH)); // R3
  AST_MEM_ONLY_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || mem_wr_o) |-> stall_o); // R10
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_o, mem_wr_o})); // R2
  AST_GRANT_CLEARS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> $countones(clr) == 1); // R8
endmodule

// File: tb/cycle_steal_counter_test.sv
`timescale 1ns/1ps
module cycle_steal_counter_test;
  localparam int W = 15, AW = 6, NCH = 4;
  localparam logic [AW-1:0] BASE = 6'h20;

  localparam logic [31:0] VEC [12] = '{
    {2'd0, 15'h0000, 15'h0001},
    {2'd0, 15'h7FFE, 15'h7FFF},
    {2'd0, 15'h7FFF, 15'h0001},
    {2'd0, 15'h3FFF, 15'h4000},
    {2'd1, 15'h0005, 15'h0004},
    {2'd1, 15'h0000, 15'h7FFE},
    {2'd1, 15'h7FFF, 15'h7FFE},
    {2'd1, 15'h0001, 15'h7FFF},
    {2'd2, 15'h0000, 15'h0001},
    {2'd2, 15'h4001, 15'h0003},
    {2'd3, 15'h2AAA, 15'h5554},
    {2'd3, 15'h4000, 15'h0000}
  };

  logic clk = 0, rst_n = 0, boundary = 0;
  logic [NCH-1:0] req = '0;
  logic grant, stall, mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [W-1:0] wdata, rdata;
  logic [W-1:0] mem [64];
  int total = 0, bad = 0, stray = 0, rd_count = 0;
  logic [AW-1:0] last_rd_addr;
  bit finished = 0;

  always #2 clk = ~clk;

  cycle_steal_counter uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .boundary_i(boundary),
    .grant_o(grant), .stall_o(stall), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_addr_o(mem_addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= wdata;
    if (mem_rd) begin
      rdata <= mem[mem_addr];
      last_rd_addr <= mem_addr;
      rd_count <= rd_count + 1;
    end
    if ((mem_rd || mem_wr) && !stall) stray <= stray + 1;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    @(negedge clk) req = m;
    @(negedge clk) req = '0;
  endtask

  task automatic steal(output int n, output bit g);
    @(negedge clk) boundary = 1;
    #0.5 g = grant;
    @(negedge clk) boundary = 0;
    n = 0;
    while (stall && n < 10) begin n++; @(negedge clk); end
  endtask

  int n;
  bit g;
  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!stall && !grant && !mem_rd && !mem_wr, "R9 outputs idle in reset", {stall, grant, mem_rd, mem_wr}, 0);
    rst_n = 1;
    @(negedge clk) boundary = 1;
    #0.5 chk(!grant, "R9 nothing pending after reset", grant, 0);
    @(negedge clk) boundary = 0;

    for (int k = 0; k < 12; k++) begin
      int c;
      c = int'(VEC[k][31:30]);
      mem[BASE + AW'(c)] = VEC[k][29:15];
      pulse(NCH'(1) << c);
      steal(n, g);
      chk(g, "R1 grant at boundary", g, 1);
      chk(n == 3, "R1 three stalled cycles", n, 3);
      chk(last_rd_addr == BASE + AW'(c), "R3 fixed address", last_rd_addr, BASE + AW'(c));
      chk(mem[BASE + AW'(c)] == VEC[k][14:0], "R4 R5 R6 result", mem[BASE + AW'(c)], VEC[k][14:0]);
    end

    mem[BASE] = 15'h0010;
    pulse(4'b0001);
    repeat (6) @(negedge clk);
    chk(!stall && rd_count == 12, "R7 R1 no steal without boundary", rd_count, 12);
    steal(n, g);
    chk(mem[BASE] == 15'h0011, "R7 sticky request serviced later", mem[BASE], 15'h0011);

    mem[BASE + 1] = 15'h0009; mem[BASE + 2] = 15'h0000;
    pulse(4'b0110);
    steal(n, g);
    chk(mem[BASE + 1] == 15'h0008 && mem[BASE + 2] == 15'h0000, "R8 lowest line first", mem[BASE + 2], 0);
    steal(n, g);
    chk(g && mem[BASE + 2] == 15'h0001, "R8 second line next steal", mem[BASE + 2], 1);

    mem[BASE] = 15'h0000;
    pulse(4'b0001);
    @(negedge clk) boundary = 1;
    @(negedge clk) boundary = 0; req = 4'b0001;
    @(negedge clk) req = '0;
    chk(stall, "R1 busy while pulse arrives", stall, 1);
    repeat (4) @(negedge clk);
    steal(n, g);
    chk(g && mem[BASE] == 15'h0002, "R7 pulse during steal kept", mem[BASE], 2);

    mem[BASE + 3] = 15'h0001;
    pulse(4'b1000);
    pulse(4'b1000);
    steal(n, g);
    steal(n, g);
    chk(!g && mem[BASE + 3] == 15'h0002, "R7 repeated pulses merge", mem[BASE + 3], 2);
    chk(stray == 0, "R10 no memory access outside steal", stray, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule